// File: doc/BRIEF.md
# Accumulator Store Rounding Unit

This block produces the 16-bit word that goes to data memory when a 40-bit accumulator is stored. It sees the whole accumulator (8 guard bits, a 16-bit upper word and a 16-bit lower word) and a request that says what kind of store is under way. For a rounding store or an accumulator write-back it rounds the upper word using the lower word. For any other store it passes the upper word through unchanged. The accumulator is only an input here, so rounding affects the stored copy and never the accumulator itself.

Two rounding methods can be chosen at run time through a small control register. Conventional rounding always rounds a lower word of exactly one half upward. Convergent rounding breaks that tie toward an even upper word. Convergent rounding is the reset default. An optional saturation stage clamps the stored word when the rounded 24-bit upper value no longer fits in a signed 16-bit word. The result and its write strobe are registered and appear one clock after the request.

Top module: `acc_store_round`

## Requirements
- R1: After reset the control register reads 0x0000, so convergent rounding is selected and saturation is off, and `st_valid` is 0.
- R2: Control register bit 1 selects the rounding method (1 = conventional, 0 = convergent) and bit 2 enables store saturation (1 = on). Writing any value makes every other bit read as 0.
- R3: In conventional mode a rounding store increments the upper value whenever accumulator bit 15 is 1.
- R4: In convergent mode a rounding store increments only when the lower word is above 0x8000, or when it equals 0x8000 and accumulator bit 16 is 1. A lower word of exactly 0x8000 with bit 16 at 0 gives no increment.
- R5: Rounding applies only to `rnd_store_req` and `wb_req`. A `plain_store_req` stores accumulator bits 31:16 unchanged, whatever the lower word holds.
- R6: A request in cycle N makes `st_valid` 1 for exactly cycle N+1, with the result on `st_data`. With no request, `st_valid` is 0 and `st_data` holds its last value.
- R7: The increment carries across the full 24-bit upper value (accumulator bits 39:16). With saturation off, the stored word is the low 16 bits of that sum. With saturation on and the sum outside the signed 16-bit range, the stored word is 0x7FFF for a positive sum and 0x8000 for a negative one.
- R8: A control write and a store request in the same cycle: the store uses the register contents from before the write.
- R9: If a plain store and a rounding request are both asserted in one cycle, rounding is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Write strobe for the control register |
| ctl_wr_data | input | 16 | Data written to the control register |
| ctl_rd_data | output | 16 | Current control register contents |
| acc_in | input | 40 | Accumulator value: guard bits 39:32, upper word 31:16, lower word 15:0 |
| rnd_store_req | input | 1 | Store with rounding |
| wb_req | input | 1 | Accumulator write-back (rounded) |
| plain_store_req | input | 1 | Store without rounding |
| st_data | output | 16 | Registered word to be stored |
| st_valid | output | 1 | Single-cycle write strobe for `st_data` |

## Verification
There are two same-cycle overlaps. The first is a control register write that changes the rounding method in the same cycle as a rounding store of a tie value. The bench drives both on one edge and expects the tie to be resolved by the old method, then sees the new method on the following store. The second is a round-up and saturation in the same cycle: an upper word of 0x7FFF with a lower word of 0x8000 under conventional rounding must wrap to 0x8000 with saturation off and clamp to 0x7FFF with it on. A plain store asserted together with a rounding request is also checked to confirm that rounding wins.

// File: rtl/acc_round_pkg.sv
package acc_round_pkg;
  typedef enum logic {
    RMODE_CONVERGENT   = 1'b0,
    RMODE_CONVENTIONAL = 1'b1
  } rmode_e;

  localparam int CTL_W        = 16;
  localparam int CTL_MODE_BIT = 1;
  localparam int CTL_SAT_BIT  = 2;
endpackage

// File: rtl/acc_round_ctl.sv
module acc_round_ctl
  import acc_round_pkg::*;
#(
  parameter int CW = CTL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output rmode_e        mode,
  output logic          sat_en,
  output logic [CW-1:0] rd_data
);
  rmode_e mode_q, mode_d;
  logic   sat_q, sat_d;

  always_comb begin
    mode_d = mode_q;
    sat_d  = sat_q;
    if (wr_en) begin
      mode_d = rmode_e'(wr_data[CTL_MODE_BIT]);
      sat_d  = wr_data[CTL_SAT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RMODE_CONVERGENT;
      sat_q  <= 1'b0;
    end else if (wr_en) begin
      mode_q <= mode_d;
      sat_q  <= sat_d;
    end
  end

  always_comb begin
    rd_data               = '0;
    rd_data[CTL_MODE_BIT] = mode_q;
    rd_data[CTL_SAT_BIT]  = sat_q;
  end

  assign mode   = mode_q;
  assign sat_en = sat_q;
endmodule

// File: rtl/acc_round_decide.sv
module acc_round_decide
  import acc_round_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int GUARD_W = 8,
  localparam int UP_W   = WORD_W + GUARD_W
) (
  input  logic [UP_W-1:0]   upper,
  input  logic [WORD_W-1:0] lower,
  input  logic              round_en,
  input  rmode_e            mode,
  output logic              round_up,
  output logic [UP_W-1:0]   sum
);
  localparam logic [WORD_W-1:0] HALF = {1'b1, {(WORD_W-1){1'b0}}};

  logic above_half, at_half, conv_up, cvg_up;

  always_comb begin
    above_half = lower > HALF;
    at_half    = lower == HALF;
    conv_up    = lower[WORD_W-1];
    cvg_up     = above_half | (at_half & upper[0]);
    round_up   = 1'b0;
    if (round_en) begin
      round_up = (mode == RMODE_CONVENTIONAL) ? conv_up : cvg_up;
    end
    sum = upper + UP_W'(round_up);
  end
endmodule

// File: rtl/acc_round_sat.sv
module acc_round_sat #(
  parameter int WORD_W  = 16,
  parameter int GUARD_W = 8,
  localparam int UP_W   = WORD_W + GUARD_W
) (
  input  logic [UP_W-1:0]   value,
  input  logic              sat_en,
  output logic              ovf,
  output logic [WORD_W-1:0] word
);
  localparam logic [WORD_W-1:0] POS_MAX = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] NEG_MIN = {1'b1, {(WORD_W-1){1'b0}}};

  logic [UP_W-WORD_W:0] top_bits;

  always_comb begin
    top_bits = value[UP_W-1:WORD_W-1];
    ovf      = !((&top_bits) | ~(|top_bits));
    word     = value[WORD_W-1:0];
    if (sat_en && ovf) begin
      word = value[UP_W-1] ? NEG_MIN : POS_MAX;
    end
  end
endmodule

// File: rtl/acc_store_round.sv
module acc_store_round
  import acc_round_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int GUARD_W = 8,
  localparam int ACC_W  = GUARD_W + 2 * WORD_W,
  localparam int UP_W   = GUARD_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_en,
  input  logic [CTL_W-1:0]  ctl_wr_data,
  output logic [CTL_W-1:0]  ctl_rd_data,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic              rnd_store_req,
  input  logic              wb_req,
  input  logic              plain_store_req,
  output logic [WORD_W-1:0] st_data,
  output logic              st_valid
);
  rmode_e            mode;
  logic              sat_en;
  logic              round_en, any_req, round_up, ovf;
  logic [UP_W-1:0]   sum;
  logic [WORD_W-1:0] sat_word;
  logic [WORD_W-1:0] data_q, data_d;
  logic              valid_q, valid_d;

  acc_round_ctl #(.CW(CTL_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr_en),
    .wr_data (ctl_wr_data),
    .mode    (mode),
    .sat_en  (sat_en),
    .rd_data (ctl_rd_data)
  );

  acc_round_decide #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_decide (
    .upper    (acc_in[ACC_W-1:WORD_W]),
    .lower    (acc_in[WORD_W-1:0]),
    .round_en (round_en),
    .mode     (mode),
    .round_up (round_up),
    .sum      (sum)
  );

  acc_round_sat #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_sat (
    .value  (sum),
    .sat_en (sat_en),
    .ovf    (ovf),
    .word   (sat_word)
  );

  always_comb begin
    round_en = rnd_store_req | wb_req;
    any_req  = round_en | plain_store_req;
    valid_d  = any_req;
    data_d   = any_req ? sat_word : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (any_req) begin
      data_q <= data_d;
    end
  end

  assign st_data  = data_q;
  assign st_valid = valid_q;
endmodule

// File: rtl/acc_store_round_chk.sv
module acc_store_round_chk #(
  parameter int WORD_W  = 16,
  parameter int GUARD_W = 8,
  localparam int ACC_W  = GUARD_W + 2 * WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       ctl_rd_data,
  input logic [ACC_W-1:0]  acc_in,
  input logic              rnd_store_req,
  input logic              wb_req,
  input logic              plain_store_req,
  input logic [WORD_W-1:0] st_data,
  input logic              st_valid
);
  logic any_req;
  assign any_req = rnd_store_req | wb_req | plain_store_req;

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> st_valid); // R6

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> !st_valid); // R6

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> $stable(st_data)); // R6

  AST_CTL_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd_data & 16'hFFF9) == 16'h0000); // R2

  AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_store_req && !rnd_store_req && !wb_req && !ctl_rd_data[2])
      |=> st_data == $past(acc_in[2*WORD_W-1:WORD_W])); // R5

  AST_EVEN_TIE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_store_req && !ctl_rd_data[1] && !ctl_rd_data[2]
      && acc_in[WORD_W-1:0] == 16'h8000 && !acc_in[WORD_W])
      |=> st_data == $past(acc_in[2*WORD_W-1:WORD_W])); // R4
endmodule

bind acc_store_round acc_store_round_chk #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ctl_rd_data     (ctl_rd_data),
  .acc_in          (acc_in),
  .rnd_store_req   (rnd_store_req),
  .wb_req          (wb_req),
  .plain_store_req (plain_store_req),
  .st_data         (st_data),
  .st_valid        (st_valid)
);

// File: tb/acc_store_round_bench.sv
module acc_store_round_bench;
  localparam int K_PLAIN = 0;
  localparam int K_RND   = 1;
  localparam int K_WB    = 2;
  localparam int K_BOTH  = 3;

  logic        clk;
  logic        rst_n;
  logic        ctl_wr_en;
  logic [15:0] ctl_wr_data;
  logic [15:0] ctl_rd_data;
  logic [39:0] acc_in;
  logic        rnd_store_req, wb_req, plain_store_req;
  logic [15:0] st_data;
  logic        st_valid;

  int checks = 0;
  int errors = 0;

  acc_store_round u_acc_store_round (
    .clk             (clk),
    .rst_n           (rst_n),
    .ctl_wr_en       (ctl_wr_en),
    .ctl_wr_data     (ctl_wr_data),
    .ctl_rd_data     (ctl_rd_data),
    .acc_in          (acc_in),
    .rnd_store_req   (rnd_store_req),
    .wb_req          (wb_req),
    .plain_store_req (plain_store_req),
    .st_data         (st_data),
    .st_valid        (st_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [15:0] v);
    @(negedge clk);
    ctl_wr_en   = 1'b1;
    ctl_wr_data = v;
    @(negedge clk);
    ctl_wr_en   = 1'b0;
  endtask

  // One request cycle; checks the strobe and the stored word one clock later.
  task automatic store(input string tag, input int kind, input logic [39:0] acc,
                       input logic [15:0] exp);
    @(negedge clk);
    acc_in          = acc;
    plain_store_req = (kind == K_PLAIN) || (kind == K_BOTH);
    rnd_store_req   = (kind == K_RND) || (kind == K_BOTH);
    wb_req          = (kind == K_WB);
    @(negedge clk);
    plain_store_req = 1'b0;
    rnd_store_req   = 1'b0;
    wb_req          = 1'b0;
    check({tag, " strobe"}, {15'd0, st_valid}, 16'd1);
    check({tag, " data"}, st_data, exp);
  endtask

  task automatic t_reset;
    check("R1 ctl after reset", ctl_rd_data, 16'h0000);
    check("R1 strobe after reset", {15'd0, st_valid}, 16'd0);
  endtask

  task automatic t_ctl_bits;
    write_ctl(16'hFFFF);
    check("R2 spare bits read zero", ctl_rd_data, 16'h0006);
    write_ctl(16'h0000);
    check("R2 cleared", ctl_rd_data, 16'h0000);
  endtask

  task automatic t_convergent;
    store("R4 tie even kept", K_RND, 40'h00_1234_8000, 16'h1234);
    store("R4 tie odd up", K_RND, 40'h00_1235_8000, 16'h1236);
    store("R4 above half", K_RND, 40'h00_1234_8001, 16'h1235);
    store("R4 below half", K_RND, 40'h00_1234_7FFF, 16'h1234);
    store("R4 write-back rounds", K_WB, 40'h00_0001_C000, 16'h0002);
  endtask

  task automatic t_conventional;
    write_ctl(16'h0002);
    store("R3 tie up", K_RND, 40'h00_1234_8000, 16'h1235);
    store("R3 below half", K_RND, 40'h00_1234_7FFF, 16'h1234);
    store("R3 write-back", K_WB, 40'h00_2222_FFFF, 16'h2223);
  endtask

  task automatic t_plain;
    store("R5 plain ignores low word", K_PLAIN, 40'h00_1235_FFFF, 16'h1235);
    store("R9 plain plus round", K_BOTH, 40'h00_1235_FFFF, 16'h1236);
  endtask

  task automatic t_strobe_hold;
    @(negedge clk);
    check("R6 strobe single cycle", {15'd0, st_valid}, 16'd0);
    acc_in = 40'h00_5555_0000;
    @(negedge clk);
    check("R6 data held", st_data, 16'h1236);
  endtask

  task automatic t_saturate;
    write_ctl(16'h0002);
    store("R7 wrap without sat", K_RND, 40'h00_7FFF_8000, 16'h8000);
    store("R7 carry into guard", K_RND, 40'hFF_FFFF_8000, 16'h0000);
    write_ctl(16'h0006);
    store("R7 clamp positive", K_RND, 40'h00_7FFF_8000, 16'h7FFF);
    store("R7 min in range", K_PLAIN, 40'hFF_8000_0000, 16'h8000);
    store("R7 clamp negative", K_PLAIN, 40'hFE_0000_0000, 16'h8000);
    store("R7 in range passes", K_RND, 40'h00_0100_9000, 16'h0101);
  endtask

  task automatic t_same_cycle;
    write_ctl(16'h0000);
    @(negedge clk);
    ctl_wr_en     = 1'b1;
    ctl_wr_data   = 16'h0002;
    acc_in        = 40'h00_1234_8000;
    rnd_store_req = 1'b1;
    @(negedge clk);
    ctl_wr_en     = 1'b0;
    rnd_store_req = 1'b0;
    check("R8 old mode used", st_data, 16'h1234);
    check("R8 new mode stored", ctl_rd_data, 16'h0002);
    store("R8 new mode next store", K_RND, 40'h00_1234_8000, 16'h1235);
  endtask

  initial begin
    rst_n           = 1'b0;
    ctl_wr_en       = 1'b0;
    ctl_wr_data     = '0;
    acc_in          = '0;
    rnd_store_req   = 1'b0;
    wb_req          = 1'b0;
    plain_store_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctl_bits();
    t_convergent();
    t_conventional();
    t_plain();
    t_strobe_hold();
    t_saturate();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule